// File: doc/BRIEF.md
# Two-Mode LCD Drive Waveform Sequencer

This block turns eight bytes of segment data plus a mode bit and a bank bit into the drive pattern for 32 LCD segments and two backplanes. Each output is a 2-bit level code. An external analog stage turns the codes into voltages. A prescaler divides the system clock so that one full display frame lasts `FRAME_CYCLES` clocks. A phase counter then steps through either a 2-phase single-backplane pattern (direct drive) or a 4-phase half-bias dual-backplane pattern (duplex drive).

Mode, bank and segment data are copied into shadow registers only when a new frame begins, so a frame is never shown half-updated. Several instances can share one display. The master exports a phase-advance strobe and the phase being entered. A cascaded instance takes that strobe and phase in place of its own prescaler, so it switches at the same clock edge as the master.

Top module: `lcd_wave_seq`

## Requirements
- R1: After reset, and until the first frame start, every segment code is low (2'b00). Both backplane codes are low (2'b00) when `cascade_en` is 0, and high-Z (2'b11) when it is 1. The other codes are mid = 2'b01 and high = 2'b10.
- R2: When `cascade_en` is 0, the phase advances after every `FRAME_CYCLES/2` clocks in direct drive and after every `FRAME_CYCLES/4` clocks in duplex drive. A frame therefore always lasts `FRAME_CYCLES` clocks. The first advance after reset enters phase 0.
- R3: In direct drive (latched mode 0), `bp1_lvl` is high in phase 0 and low in phase 1, and `bp2_lvl` is low. A segment whose bit is set is driven to the opposite level from `bp1_lvl`. A segment whose bit is clear is driven to the same level as `bp1_lvl`.
- R4: In direct drive, segment 8g+b (g = 0..3, b = 0..7) takes bit b of register 2g+bank. Register k is `seg_data[8k+7:8k]`.
- R5: In duplex drive (latched mode 1), the phases 0..3 give `bp1_lvl` = high, low, mid, mid and `bp2_lvl` = mid, mid, high, low. Exactly one backplane is at mid in each phase.
- R6: In duplex drive, phases 0 and 1 use bit b of register 2g, and phases 2 and 3 use bit b of register 2g+1. The extreme level in use is high in phases 0 and 2 and low in phases 1 and 3. A set bit drives the segment to the opposite extreme and a clear bit drives it to the same extreme. The bank bit has no effect.
- R7: Over every complete frame, each segment spends as many clocks at high as at low, so the drive has no DC component.
- R8: Changes to `seg_data`, `mode_duplex` or `bank_sel` have no effect on any output until the next entry into phase 0.
- R9: When `cascade_en` is 1, the local prescaler is ignored. On a clock where `sync_strobe_in` is 1, the phase becomes `sync_phase_in` at that edge. Entering phase 0 this way starts a frame.
- R10: `sync_strobe_out` is 1 exactly on the clocks that end with a phase advance, and `sync_phase_out` is then the phase being entered. The phase does not change on any other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_data | input | NUM_REGS*REG_W | Segment registers, register k at bits [8k+7:8k] |
| mode_duplex | input | 1 | 0 = direct drive, 1 = duplex drive |
| bank_sel | input | 1 | Direct-drive bank: 0 = even registers, 1 = odd registers |
| cascade_en | input | 1 | 1 = follow the external phase strobe |
| sync_strobe_in | input | 1 | External phase-advance strobe |
| sync_phase_in | input | 2 | Phase entered on the external strobe |
| seg_lvl | output | 2*NUM_SEG | Segment level codes, segment i at [2i+1:2i] |
| bp1_lvl | output | 2 | Backplane 1 level code |
| bp2_lvl | output | 2 | Backplane 2 level code |
| sync_strobe_out | output | 1 | Phase-advance strobe for cascaded instances |
| sync_phase_out | output | 2 | Phase entered on this advance |

## Verification
The bench builds the block with `FRAME_CYCLES = 16`, which gives 8-clock direct phases and 4-clock duplex phases. Hundreds of whole frames then fit in a short run, so frame boundaries, mode switches at a boundary, and changes made mid-frame occur very often. The register count and width stay at 8 by 8, so all 32 segments and both bank choices are visible at the ports. Cascade tests drive the external strobe at irregular gaps and with out-of-order phases.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_HIZ  = 2'd3
  } lvl_t;

  // Phase that follows ph inside a frame; frame is 2 phases direct, 4 duplex.
  function automatic logic [1:0] phase_after(input logic [1:0] ph, input logic duplex);
    logic [1:0] last;
    last = duplex ? 2'd3 : 2'd1;
    return (ph >= last) ? 2'd0 : ph + 2'd1;
  endfunction

  // Extreme level of the backplane that is active in this phase.
  function automatic lvl_t active_extreme(input logic [1:0] ph);
    return ph[0] ? LVL_LOW : LVL_HIGH;
  endfunction

  // Segment level relative to the active extreme: set bit = antiphase.
  function automatic lvl_t seg_drive(input lvl_t ext, input logic on);
    if (!on) return ext;
    return (ext == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
  endfunction

  function automatic lvl_t duplex_bp(input logic [1:0] ph, input logic second);
    // first backplane active in phases 0,1; second in phases 2,3
    if (ph[1] != second) return LVL_MID;
    return active_extreme(ph);
  endfunction

endpackage

// File: rtl/lcd_frame_prescaler.sv
module lcd_frame_prescaler #(
  parameter int FRAME_CYCLES = 2777776
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic duplex,
  output logic tick
);
  localparam int DIR_LEN = FRAME_CYCLES / 2;
  localparam int DUP_LEN = FRAME_CYCLES / 4;
  localparam int CW      = (DIR_LEN > 1) ? $clog2(DIR_LEN) : 1;
  localparam logic [CW-1:0] DIR_LAST = CW'(DIR_LEN - 1);
  localparam logic [CW-1:0] DUP_LAST = CW'(DUP_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;

  assign last_cnt = duplex ? DUP_LAST : DIR_LAST;
  assign tick     = !hold && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (hold)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt); // R2

endmodule

// File: rtl/lcd_phase_ctrl.sv
module lcd_phase_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              local_tick,
  input  logic              cascade_en,
  input  logic              sync_strobe_in,
  input  logic [1:0]        sync_phase_in,
  input  logic              mode_in,
  input  logic              bank_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              adv,
  output logic [1:0]        nxt_phase,
  output logic              frame_start,
  output logic [1:0]        phase_q,
  output logic              run_q,
  output logic              mode_sh,
  output logic              bank_sh,
  output logic [DATA_W-1:0] data_sh
);

  assign adv         = cascade_en ? sync_strobe_in : local_tick;
  assign nxt_phase   = cascade_en ? sync_phase_in : phase_after(phase_q, mode_sh);
  assign frame_start = adv && (nxt_phase == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 2'd3;
      run_q   <= 1'b0;
      mode_sh <= 1'b0;
      bank_sh <= 1'b0;
      data_sh <= '0;
    end else begin
      if (adv) phase_q <= nxt_phase;
      if (frame_start) begin
        run_q   <= 1'b1;
        mode_sh <= mode_in;
        bank_sh <= bank_in;
        data_sh <= data_in;
      end
    end
  end

  AST_SHADOW_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(data_sh) && $stable(mode_sh) && $stable(bank_sh))); // R8

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(phase_q)); // R10

  AST_CASCADE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_en && sync_strobe_in) |=> (phase_q == $past(sync_phase_in))); // R9

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_seq_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   phase,
  input  logic                         run,
  input  logic                         duplex,
  input  logic                         bank,
  input  logic                         cascade_en,
  input  logic [NUM_REGS*REG_W-1:0]    data,
  output logic [NUM_REGS/2*REG_W*2-1:0] seg_lvl,
  output logic [1:0]                   bp1_lvl,
  output logic [1:0]                   bp2_lvl
);
  localparam int NUM_SEG = NUM_REGS / 2 * REG_W;

  lvl_t ext_lvl;
  logic sel_odd;

  assign ext_lvl = active_extreme(phase);
  assign sel_odd = duplex ? phase[1] : bank;

  always_comb begin
    if (!run) begin
      bp1_lvl = cascade_en ? LVL_HIZ : LVL_LOW;
      bp2_lvl = cascade_en ? LVL_HIZ : LVL_LOW;
    end else if (duplex) begin
      bp1_lvl = duplex_bp(phase, 1'b0);
      bp2_lvl = duplex_bp(phase, 1'b1);
    end else begin
      bp1_lvl = ext_lvl;
      bp2_lvl = LVL_LOW;
    end
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam int GRP = i / REG_W;
    localparam int BIT = i % REG_W;
    logic even_bit, odd_bit, on_bit;
    assign even_bit = data[(2*GRP)*REG_W + BIT];
    assign odd_bit  = data[(2*GRP+1)*REG_W + BIT];
    assign on_bit   = sel_odd ? odd_bit : even_bit;
    assign seg_lvl[2*i +: 2] = run ? seg_drive(ext_lvl, on_bit) : LVL_LOW;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (seg_lvl == '0)); // R1

  AST_DUPLEX_ONE_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (run && duplex) |-> ((bp1_lvl == LVL_MID) != (bp2_lvl == LVL_MID))); // R5

  AST_DIRECT_BP2_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !duplex) |-> (bp2_lvl == LVL_LOW && bp1_lvl != LVL_MID)); // R3

endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
  import lcd_seq_pkg::*;
#(
  parameter int FRAME_CYCLES = 2777776,
  parameter int NUM_REGS     = 8,
  parameter int REG_W        = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_REGS*REG_W-1:0]     seg_data,
  input  logic                          mode_duplex,
  input  logic                          bank_sel,
  input  logic                          cascade_en,
  input  logic                          sync_strobe_in,
  input  logic [1:0]                    sync_phase_in,
  output logic [NUM_REGS/2*REG_W*2-1:0] seg_lvl,
  output logic [1:0]                    bp1_lvl,
  output logic [1:0]                    bp2_lvl,
  output logic                          sync_strobe_out,
  output logic [1:0]                    sync_phase_out
);
  localparam int DATA_W = NUM_REGS * REG_W;

  logic              local_tick;
  logic              adv;
  logic [1:0]        nxt_phase;
  logic              frame_start;
  logic [1:0]        phase_q;
  logic              run_q;
  logic              mode_sh;
  logic              bank_sh;
  logic [DATA_W-1:0] data_sh;

  lcd_frame_prescaler #(.FRAME_CYCLES(FRAME_CYCLES)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (cascade_en),
    .duplex (mode_sh),
    .tick   (local_tick)
  );

  lcd_phase_ctrl #(.DATA_W(DATA_W)) u_phase (
    .clk            (clk),
    .rst_n          (rst_n),
    .local_tick     (local_tick),
    .cascade_en     (cascade_en),
    .sync_strobe_in (sync_strobe_in),
    .sync_phase_in  (sync_phase_in),
    .mode_in        (mode_duplex),
    .bank_in        (bank_sel),
    .data_in        (seg_data),
    .adv            (adv),
    .nxt_phase      (nxt_phase),
    .frame_start    (frame_start),
    .phase_q        (phase_q),
    .run_q          (run_q),
    .mode_sh        (mode_sh),
    .bank_sh        (bank_sh),
    .data_sh        (data_sh)
  );

  lcd_level_map #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase_q),
    .run        (run_q),
    .duplex     (mode_sh),
    .bank       (bank_sh),
    .cascade_en (cascade_en),
    .data       (data_sh),
    .seg_lvl    (seg_lvl),
    .bp1_lvl    (bp1_lvl),
    .bp2_lvl    (bp2_lvl)
  );

  assign sync_strobe_out = adv;
  assign sync_phase_out  = nxt_phase;

  AST_RUN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> run_q && phase_q == 2'd0); // R9

endmodule

// File: tb/lcd_wave_seq_tb.sv
`timescale 1ns/1ps
module lcd_wave_seq_tb;
  localparam int FC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] seg_data = '0;
  logic        mode_duplex = 1'b0, bank_sel = 1'b0, cascade_en = 1'b0;
  logic        sync_strobe_in = 1'b0;
  logic [1:0]  sync_phase_in = 2'd0;
  logic [63:0] seg_lvl;
  logic [1:0]  bp1_lvl, bp2_lvl, sync_phase_out;
  logic        sync_strobe_out;

  always #2 clk = ~clk;

  lcd_wave_seq #(.FRAME_CYCLES(FC)) u_dut (
    .clk(clk), .rst_n(rst_n), .seg_data(seg_data), .mode_duplex(mode_duplex),
    .bank_sel(bank_sel), .cascade_en(cascade_en), .sync_strobe_in(sync_strobe_in),
    .sync_phase_in(sync_phase_in), .seg_lvl(seg_lvl), .bp1_lvl(bp1_lvl),
    .bp2_lvl(bp2_lvl), .sync_strobe_out(sync_strobe_out), .sync_phase_out(sync_phase_out)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // bench model state
  int          m_cnt;
  logic [1:0]  m_phase;
  bit          m_run, m_dup, m_bank, dc_valid;
  logic [63:0] m_data;
  int          hi_cnt [32];
  int          lo_cnt [32];

  function automatic logic [1:0] e_bp(input int which);
    if (!m_run) return cascade_en ? 2'd3 : 2'd0;
    if (!m_dup) return (which == 1) ? ((m_phase == 0) ? 2'd2 : 2'd0) : 2'd0;
    case ({which[1:0], m_phase})
      {2'd1, 2'd0}: return 2'd2;
      {2'd1, 2'd1}: return 2'd0;
      {2'd2, 2'd2}: return 2'd2;
      {2'd2, 2'd3}: return 2'd0;
      default:      return 2'd1;
    endcase
  endfunction

  function automatic logic [1:0] e_seg(input int i);
    int r; logic bitv; logic [1:0] ext;
    if (!m_run) return 2'd0;
    r    = 2 * (i / 8) + (m_dup ? int'(m_phase >= 2) : int'(m_bank));
    bitv = m_data[r*8 + i%8];
    ext  = (m_phase == 0 || m_phase == 2) ? 2'd2 : 2'd0;
    return bitv ? (2'd2 - ext) : ext;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [63:0] es;
    string t;
    for (int i = 0; i < 32; i++) es[2*i +: 2] = e_seg(i);
    if (tag != "") t = tag;
    else if (!m_run) t = "R1";
    else if (m_dup) t = "R5 R6";
    else t = "R3 R4";
    chk({t, " seg"}, seg_lvl, es);
    chk({t, " bp"}, {60'd0, bp1_lvl, bp2_lvl}, {60'd0, e_bp(1), e_bp(2)});
  endtask

  task automatic model_reset();
    m_cnt = 0; m_phase = 2'd3; m_run = 0; m_dup = 0; m_bank = 0; m_data = '0;
    dc_valid = 0;
    for (int i = 0; i < 32; i++) begin hi_cnt[i] = 0; lo_cnt[i] = 0; end
  endtask

  task automatic step(input string tag = "");
    bit adv; logic [1:0] nx; int len;
    #1;
    len = m_dup ? FC/4 : FC/2;
    adv = cascade_en ? sync_strobe_in : (m_cnt == len - 1);
    nx  = cascade_en ? sync_phase_in
                     : ((m_phase >= (m_dup ? 2'd3 : 2'd1)) ? 2'd0 : m_phase + 2'd1);
    chk(cascade_en ? "R9 strobe" : "R2 R10 strobe", {63'd0, sync_strobe_out}, {63'd0, adv});
    if (adv) chk("R10 phase_out", {62'd0, sync_phase_out}, {62'd0, nx});
    @(posedge clk);
    #1;
    if (cascade_en || adv) m_cnt = 0; else m_cnt++;
    if (adv) begin
      if (nx == 2'd0) begin
        if (dc_valid) begin
          int bad; bad = -1;
          for (int i = 0; i < 32; i++) if (hi_cnt[i] != lo_cnt[i]) bad = i;
          chk("R7 dc balance", (bad < 0) ? 64'd0 : {32'(hi_cnt[bad]), 32'(lo_cnt[bad])}, 64'd0);
        end
        for (int i = 0; i < 32; i++) begin hi_cnt[i] = 0; lo_cnt[i] = 0; end
        dc_valid = !cascade_en;
        m_run = 1; m_dup = mode_duplex; m_bank = bank_sel; m_data = seg_data;
      end
      m_phase = nx;
    end
    if (cascade_en) dc_valid = 0;
    compare(tag);
    if (m_run)
      for (int i = 0; i < 32; i++)
        if (seg_lvl[2*i +: 2] == 2'd2) hi_cnt[i]++; else lo_cnt[i]++;
  endtask

  task automatic do_reset(input bit casc);
    cascade_en = casc; sync_strobe_in = 0; rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    compare("R1 in reset");
    rst_n = 1;
  endtask

  task automatic to_frame_start();
    do step(); while (!(m_phase == 0 && m_cnt == 0));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: master reset, first frame at FC/2 clocks (R2)
    do_reset(1'b0);
    seg_data = 64'hA5C3_0FF0_1234_8001;
    repeat (FC/2 + 2) step();
    // R3 R4: direct drive, even bank then odd bank
    to_frame_start();
    repeat (2*FC) step();
    bank_sel = 1; seg_data = 64'h0F0F_F0F0_55AA_33CC;
    repeat (2*FC + 3) step();
    // R8: change everything mid-frame, outputs keep last frame
    to_frame_start();
    repeat (3) step();
    seg_data = ~seg_data; bank_sel = 0; mode_duplex = 1;
    while (!(m_phase == 0 && m_cnt == 0)) step("R8 mid-frame hold");
    // R5 R6: duplex with bank toggling ignored
    repeat (FC) step();
    bank_sel = 1;
    repeat (2*FC) step("R6 bank ignored");
    seg_data = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (2*FC) step();
    seg_data = 64'h0;
    repeat (2*FC) step();
    // random stimulus
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 16) == 0) begin
        case ($urandom % 3)
          0: seg_data = {$urandom, $urandom};
          1: mode_duplex = $urandom % 2;
          default: bank_sel = $urandom % 2;
        endcase
      end
      step();
    end
    // R1 R9: cascade reset gives high-Z backplanes until phase 0 strobe
    mode_duplex = 1;
    do_reset(1'b1);
    repeat (20) step("R1 R9 cascade idle");
    for (int k = 0; k < 12; k++) begin
      sync_phase_in = 2'(k % 4); sync_strobe_in = 1;
      step("R9 follow");
      sync_strobe_in = 0;
      repeat ($urandom % 5) step("R9 follow");
    end
    // out-of-order realignment
    sync_phase_in = 2'd2; sync_strobe_in = 1; step("R9 realign");
    sync_phase_in = 2'd0; step("R9 realign");
    sync_strobe_in = 0; mode_duplex = 0; repeat (3) step("R9 realign");
    for (int k = 0; k < 6; k++) begin
      sync_phase_in = 2'(k % 2); sync_strobe_in = 1; step("R9 direct follow");
      sync_strobe_in = 0; repeat (2) step("R9 direct follow");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule